// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block walks a buffer of 32-bit command words held in a synchronous memory that has one cycle of read latency. It reads the buffer from word 0 forward, turns each command into one or more register writes on a valid/ready write bus, and stops when a command would begin at or past a programmed end position. Two command shapes are understood. A single write stores its data word first and its control word second. A burst write stores a repeat count first and its control word second, and then carries that many data words, which all go to one register. Every command begins on an even word index. When a burst payload leaves the next free index odd, the word there is padding and is skipped.

Software fills the buffer, sets the end position and pulses `start`. `busy` stays high while the command stream runs. When the stream finishes, `done` rises and holds. If the stream halts on a control word whose opcode is not recognised, `err` rises and holds instead, and `err_idx` gives the index at which that command began. Both flags hold until the next accepted start. The write bus has no depth of its own: while a write waits for `wr_ready`, fetching stops.

The controller is a single state machine. Its states are: `ST_IDLE` (waiting; flags hold), `ST_FETCH` (compares the index with the end position and reads the first word), `ST_HDR0` (captures the first word and reads the second), `ST_HDR1` (decodes the control word), `ST_PLAIN` (offers a single write), `ST_PLD_RD` (reads a burst data word), `ST_PLD_GET` (captures it) and `ST_PLD_WR` (offers it). The transitions are as follows:
- `ST_IDLE` goes to `ST_FETCH` when `start` is seen.
- `ST_FETCH` goes to `ST_IDLE` when the index has reached the end position. Otherwise it goes to `ST_HDR0`.
- `ST_HDR0` always goes to `ST_HDR1`.
- `ST_HDR1` goes to `ST_PLAIN` for a single write, to `ST_PLD_RD` for a burst, to `ST_FETCH` for a burst with a count of zero, and to `ST_IDLE` for an unknown opcode.
- `ST_PLAIN` goes to `ST_FETCH` once the write is accepted.
- `ST_PLD_RD` always goes to `ST_PLD_GET`, and `ST_PLD_GET` always goes to `ST_PLD_WR`.
- `ST_PLD_WR` goes to `ST_PLD_RD` after an accepted write that was not the last. It goes to `ST_FETCH` after the last one.

Top module: `regseq_exec`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `wr_valid` and `mem_rd_en` are all low.
- R2: A `start` pulse seen while `busy` is low begins execution at word 0, clears `done` and `err`, and raises `busy` on the following cycle. A `start` pulse seen while `busy` is high has no effect.
- R3: A single-write command occupies two words. Word k is the data. Word k+1 is the control word, with opcode 8'h01 in bits 31:24, the byte strobes in bits 23:20 and the register offset in bits 19:0. The command produces exactly one write of that data to that offset with those strobes. The next command begins at k+2.
- R4: A burst command begins at index k. Word k is a count N, of which the low CNT_W bits are used. Word k+1 is a control word with opcode 8'h09 in bits 31:24 and the offset in bits 19:0. Words k+2 to k+1+N are written in order to that offset, each with strobes 4'hF.
- R5: After a burst, the next command begins at the first even index at or above k+2+N. When that value is odd, the word at k+2+N is skipped whatever it contains.
- R6: A burst with a count of zero issues no write, and the next command begins at k+2.
- R7: An opcode other than 8'h01 or 8'h09 stops execution. `busy` falls, `err` rises, `err_idx` gives the index k of the faulty command, and no further write is issued until the next start.
- R8: When a command would begin at an index of `end_idx` or above, execution ends: `busy` falls and `done` rises. With `end_idx` = 0, no write is issued. `done` and `err` are never high together, and each holds until the next accepted start.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_strb` hold steady. Each command word produces its write exactly once, whatever the pattern of `wr_ready`.
- R10: The memory is read only while `busy` is high. The data requested with `mem_rd_en` at `mem_addr` is used in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution from word 0 |
| end_idx | input | IDX_W | Word index at which execution ends |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | IDX_W | Memory word address |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| wr_valid | output | 1 | Write offered |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Write data |
| wr_strb | output | 4 | Byte strobes |
| busy | output | 1 | Execution in progress |
| done | output | 1 | Stream finished normally |
| err | output | 1 | Stream halted on an unknown opcode |
| err_idx | output | IDX_W | Start index of the faulty command |

## Verification
A wrong index is the most likely internal fault, and it shows at the ports within one command. The wrong register receives a write, a padding word appears as data, or the header decodes as an unknown opcode and `err` rises with an index that does not match. A fault in the count shows up as a burst that is one write short or one write long, and this is visible as soon as the next command should have begun. A fault in the handshake logic shows up on the first stalled cycle, as a write payload that changes or a write that repeats.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    localparam int          REG_AW     = 20;
    localparam int          DW         = 32;
    localparam int          SW         = 4;
    localparam logic [7:0]  OPC_SINGLE = 8'h01;
    localparam logic [7:0]  OPC_BURST  = 8'h09;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HDR0,
        ST_HDR1,
        ST_PLAIN,
        ST_PLD_RD,
        ST_PLD_GET,
        ST_PLD_WR
    } st_e;

    typedef enum logic [1:0] {
        CMD_SINGLE,
        CMD_BURST,
        CMD_BAD
    } cmd_e;

    typedef struct packed {
        cmd_e              kind;
        logic [SW-1:0]     strb;
        logic [REG_AW-1:0] offs;
    } dec_t;

endpackage

// File: rtl/regseq_decode.sv
module regseq_decode
    import regseq_pkg::*;
(
    input  logic [DW-1:0] ctl_word,
    output dec_t          dec
);

    always_comb begin
        dec.offs = ctl_word[REG_AW-1:0];
        dec.strb = '1;
        dec.kind = CMD_BAD;
        unique case (ctl_word[31:24])
            OPC_SINGLE: begin
                dec.kind = CMD_SINGLE;
                dec.strb = ctl_word[23:20];
            end
            OPC_BURST: begin
                dec.kind = CMD_BURST;
                dec.strb = '1;
            end
            default: begin
                dec.kind = CMD_BAD;
            end
        endcase
    end

endmodule

// File: rtl/regseq_align.sv
module regseq_align #(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] cur,
    output logic [IDX_W-1:0] nxt_seq,
    output logic [IDX_W-1:0] nxt_pair,
    output logic [IDX_W-1:0] nxt_even
);

    always_comb begin
        nxt_seq  = cur + IDX_W'(1);
        nxt_pair = cur + IDX_W'(2);
        // round the following index up to an even value
        nxt_even = nxt_seq + IDX_W'(nxt_seq[0]);
    end

endmodule

// File: rtl/regseq_wport.sv
module regseq_wport
    import regseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REG_AW-1:0] ld_addr,
    input  logic [DW-1:0]     ld_data,
    input  logic [SW-1:0]     ld_strb,
    output logic [REG_AW-1:0] q_addr,
    output logic [DW-1:0]     q_data,
    output logic [SW-1:0]     q_strb
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_data <= '0;
            q_strb <= '0;
        end else if (load) begin
            q_addr <= ld_addr;
            q_data <= ld_data;
            q_strb <= ld_strb;
        end
    end

endmodule

// File: rtl/regseq_exec.sv
module regseq_exec
    import regseq_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int CNT_W = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  end_idx,
    output logic              mem_rd_en,
    output logic [IDX_W-1:0]  mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [SW-1:0]     wr_strb,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [IDX_W-1:0]  err_idx
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    st_e               st_q, st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DW-1:0]     hdr0_q;
    logic [REG_AW-1:0] offs_q;
    logic              done_q, err_q;
    logic [IDX_W-1:0]  err_idx_q;

    logic              at_end;
    logic              wr_fire;
    logic              last_beat;
    logic [IDX_W-1:0]  idx_seq, idx_pair, idx_even;
    dec_t              dec;

    logic              wp_load;
    logic [REG_AW-1:0] wp_addr;
    logic [DW-1:0]     wp_data;
    logic [SW-1:0]     wp_strb;

    regseq_decode u_decode (
        .ctl_word (mem_rdata),
        .dec      (dec)
    );

    regseq_align #(.IDX_W(IDX_W)) u_align (
        .cur      (idx_q),
        .nxt_seq  (idx_seq),
        .nxt_pair (idx_pair),
        .nxt_even (idx_even)
    );

    regseq_wport u_wport (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wp_load),
        .ld_addr (wp_addr),
        .ld_data (wp_data),
        .ld_strb (wp_strb),
        .q_addr  (wr_addr),
        .q_data  (wr_data),
        .q_strb  (wr_strb)
    );

    assign at_end    = (idx_q >= end_idx);
    assign wr_fire   = wr_valid && wr_ready;
    assign last_beat = (cnt_q == CNT_ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = ST_FETCH;
            ST_FETCH:   st_d = at_end ? ST_IDLE : ST_HDR0;
            ST_HDR0:    st_d = ST_HDR1;
            ST_HDR1: begin
                unique case (dec.kind)
                    CMD_SINGLE: st_d = ST_PLAIN;
                    CMD_BURST:  st_d = (hdr0_q[CNT_W-1:0] == CNT_ZERO) ? ST_FETCH : ST_PLD_RD;
                    default:    st_d = ST_IDLE;
                endcase
            end
            ST_PLAIN:   if (wr_ready) st_d = ST_FETCH;
            ST_PLD_RD:  st_d = ST_PLD_GET;
            ST_PLD_GET: st_d = ST_PLD_WR;
            ST_PLD_WR:  if (wr_ready) st_d = last_beat ? ST_FETCH : ST_PLD_RD;
            default:    st_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            cnt_q     <= '0;
            hdr0_q    <= '0;
            offs_q    <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            err_idx_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q  <= '0;
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (at_end) done_q <= 1'b1;
                end
                ST_HDR0: begin
                    hdr0_q <= mem_rdata;
                end
                ST_HDR1: begin
                    unique case (dec.kind)
                        CMD_SINGLE: ;
                        CMD_BURST: begin
                            offs_q <= dec.offs;
                            cnt_q  <= hdr0_q[CNT_W-1:0];
                            idx_q  <= idx_pair;
                        end
                        default: begin
                            err_q     <= 1'b1;
                            err_idx_q <= idx_q;
                        end
                    endcase
                end
                ST_PLAIN: begin
                    if (wr_fire) idx_q <= idx_pair;
                end
                ST_PLD_WR: begin
                    if (wr_fire) begin
                        cnt_q <= cnt_q - CNT_ONE;
                        idx_q <= last_beat ? idx_even : idx_seq;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs and write-port loading
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = idx_q;
        wr_valid  = 1'b0;
        wp_load   = 1'b0;
        wp_addr   = offs_q;
        wp_data   = mem_rdata;
        wp_strb   = '1;
        unique case (st_q)
            ST_IDLE:    ;
            ST_FETCH:   mem_rd_en = !at_end;
            ST_HDR0: begin
                mem_rd_en = 1'b1;
                mem_addr  = idx_seq;
            end
            ST_HDR1: begin
                if (dec.kind == CMD_SINGLE) begin
                    wp_load = 1'b1;
                    wp_addr = dec.offs;
                    wp_data = hdr0_q;
                    wp_strb = dec.strb;
                end
            end
            ST_PLAIN:   wr_valid  = 1'b1;
            ST_PLD_RD:  mem_rd_en = 1'b1;
            ST_PLD_GET: wp_load   = 1'b1;
            ST_PLD_WR:  wr_valid  = 1'b1;
            default:    ;
        endcase
        busy    = (st_q != ST_IDLE);
        done    = done_q;
        err     = err_q;
        err_idx = err_idx_q;
    end

endmodule

// File: rtl/regseq_exec_chk.sv
module regseq_exec_chk
    import regseq_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_rd_en,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [REG_AW-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [SW-1:0]     wr_strb,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [IDX_W-1:0]  err_idx
);

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !err)); // R2

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !mem_rd_en)); // R10

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R8

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> (err && $stable(err_idx) && !busy)); // R7

    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy); // R7

endmodule

bind regseq_exec regseq_exec_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_rd_en (mem_rd_en),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_strb   (wr_strb),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_idx   (err_idx)
);

// File: tb/regseq_exec_tb.sv
`timescale 1ns/1ps
module regseq_exec_tb;

    localparam int IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] end_idx = '0;
    logic             mem_rd_en;
    logic [IDX_W-1:0] mem_addr;
    logic [31:0]      mem_rdata = '0;
    logic             wr_valid;
    logic             wr_ready;
    logic [19:0]      wr_addr;
    logic [31:0]      wr_data;
    logic [3:0]       wr_strb;
    logic             busy, done, err;
    logic [IDX_W-1:0] err_idx;

    always #10 clk = ~clk;

    regseq_exec #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .end_idx(end_idx),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .busy(busy), .done(done),
        .err(err), .err_idx(err_idx)
    );

    // command memory, one cycle read latency
    logic [31:0] mem [0:63];
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[5:0]];

    // ready pattern
    logic       bp_on = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign wr_ready = bp_on ? lfsr[0] : 1'b1;

    // write log
    logic [19:0] log_a [0:31];
    logic [31:0] log_d [0:31];
    logic [3:0]  log_s [0:31];
    int          log_n = 0;
    logic        log_clr = 1'b0;
    always @(posedge clk) begin
        if (log_clr) log_n <= 0;
        else if (wr_valid && wr_ready && log_n < 32) begin
            log_a[log_n] <= wr_addr;
            log_d[log_n] <= wr_data;
            log_s[log_n] <= wr_strb;
            log_n <= log_n + 1;
        end
    end

    logic [19:0] exp_a [0:31];
    logic [31:0] exp_d [0:31];
    logic [3:0]  exp_s [0:31];
    int          exp_n = 0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] single_ctl(input logic [19:0] offs, input logic [3:0] strb);
        return {8'h01, strb, offs};
    endfunction

    function automatic logic [31:0] burst_ctl(input logic [19:0] offs);
        return {8'h09, 4'h0, offs};
    endfunction

    task automatic clear_all();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        exp_n = 0;
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
    endtask

    task automatic add_exp(input logic [19:0] a, input logic [31:0] d, input logic [3:0] s);
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_s[exp_n] = s;
        exp_n++;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int k = 0;
        while (!(done || err) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(k < 3000, req, "run finished", k, 3000);
    endtask

    task automatic compare_log(input string req);
        check(log_n == exp_n, req, "write count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            check(log_a[i] == exp_a[i], req, "write offset", log_a[i], exp_a[i]);
            check(log_d[i] == exp_d[i], req, "write data", log_d[i], exp_d[i]);
            check(log_s[i] == exp_s[i], req, "write strobes", log_s[i], exp_s[i]);
        end
    endtask

    task automatic load_single_pair();
        clear_all();
        mem[0] = 32'h1111_2222; mem[1] = single_ctl(20'h00A40, 4'h3);
        mem[2] = 32'hCAFE_0001; mem[3] = single_ctl(20'hFFFFC, 4'hF);
        add_exp(20'h00A40, 32'h1111_2222, 4'h3);
        add_exp(20'hFFFFC, 32'hCAFE_0001, 4'hF);
    endtask

    task automatic load_burst_odd();
        clear_all();
        mem[0] = 32'd3; mem[1] = burst_ctl(20'h00100);
        mem[2] = 32'hA000_0000; mem[3] = 32'hA000_0001; mem[4] = 32'hA000_0002;
        mem[5] = 32'hDEAD_BEEF;
        mem[6] = 32'h0000_0055; mem[7] = single_ctl(20'h00200, 4'h1);
        add_exp(20'h00100, 32'hA000_0000, 4'hF);
        add_exp(20'h00100, 32'hA000_0001, 4'hF);
        add_exp(20'h00100, 32'hA000_0002, 4'hF);
        add_exp(20'h00200, 32'h0000_0055, 4'h1);
    endtask

    task automatic t_reset();
        check(!busy, "R1", "busy after reset", busy, 0);
        check(!done, "R1", "done after reset", done, 0);
        check(!err, "R1", "err after reset", err, 0);
        check(!wr_valid, "R1", "wr_valid after reset", wr_valid, 0);
        check(!mem_rd_en, "R1", "mem_rd_en after reset", mem_rd_en, 0);
    endtask

    task automatic t_single();
        load_single_pair();
        end_idx = 10'd4;
        pulse_start();
        check(busy, "R2", "busy after start", busy, 1);
        wait_end("R3");
        @(negedge clk);
        compare_log("R3"); // R10 data used one cycle after request
        check(done && !err && !busy, "R8", "done flags", {done, err, busy}, 3'b100);
    endtask

    task automatic t_burst_pad(input bit bp, input string req);
        load_burst_odd();
        bp_on = bp;
        end_idx = 10'd8;
        pulse_start();
        wait_end(req);
        @(negedge clk);
        compare_log(req); // R4 R5
        bp_on = 1'b0;
    endtask

    task automatic t_zero_count();
        clear_all();
        mem[0] = 32'd0; mem[1] = burst_ctl(20'h00300);
        mem[2] = 32'd2; mem[3] = burst_ctl(20'h00304);
        mem[4] = 32'hB000_0000; mem[5] = 32'hB000_0001;
        mem[6] = 32'h0000_00C0; mem[7] = single_ctl(20'h00308, 4'hC);
        add_exp(20'h00304, 32'hB000_0000, 4'hF);
        add_exp(20'h00304, 32'hB000_0001, 4'hF);
        add_exp(20'h00308, 32'h0000_00C0, 4'hC);
        end_idx = 10'd8;
        pulse_start();
        wait_end("R6");
        @(negedge clk);
        compare_log("R6");
    endtask

    task automatic t_bad_opcode();
        clear_all();
        mem[0] = 32'h0000_000D; mem[1] = single_ctl(20'h00010, 4'hF);
        mem[2] = 32'h0; mem[3] = {8'h05, 4'hF, 20'h00020};
        mem[4] = 32'h0000_000E; mem[5] = single_ctl(20'h00020, 4'hF);
        add_exp(20'h00010, 32'h0000_000D, 4'hF);
        end_idx = 10'd8;
        pulse_start();
        wait_end("R7");
        repeat (6) @(negedge clk);
        compare_log("R7");
        check(err, "R7", "err raised", err, 1);
        check(err_idx == 10'd2, "R7", "err_idx", err_idx, 2);
        check(!done && !busy, "R7", "done/busy low", {done, busy}, 0);
    endtask

    task automatic t_restart_after_err();
        load_single_pair();
        end_idx = 10'd4;
        pulse_start();
        check(!err, "R2", "err cleared by start", err, 0);
        wait_end("R2");
        @(negedge clk);
        compare_log("R2");
        check(done && !err, "R2", "done after restart", {done, err}, 2'b10);
    endtask

    task automatic t_end_positions();
        load_single_pair();
        end_idx = 10'd0;
        pulse_start();
        wait_end("R8");
        repeat (6) @(negedge clk);
        exp_n = 0;
        compare_log("R8");
        check(done, "R8", "done held", done, 1);
        load_single_pair();
        exp_n = 1;
        end_idx = 10'd2;
        pulse_start();
        wait_end("R8");
        @(negedge clk);
        compare_log("R8");
    endtask

    task automatic t_start_while_busy();
        load_burst_odd();
        bp_on = 1'b1;
        end_idx = 10'd8;
        pulse_start();
        repeat (8) @(negedge clk);
        check(busy, "R2", "busy before second start", busy, 1);
        pulse_start();
        wait_end("R2");
        @(negedge clk);
        compare_log("R2");
        bp_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_burst_pad(1'b0, "R4");
        t_zero_count();
        t_bad_opcode();
        t_restart_after_err();
        t_burst_pad(1'b1, "R9");
        t_end_positions();
        t_start_while_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule